// File: doc/BRIEF.md
# User-Mode Opcode Filter

This block watches the processor's bus status strobes and its 8-bit data bus. While the system runs in user mode it flags any opcode fetch that carries an instruction the supervisor reserves for itself: halting the clock, swapping the emulation flag, setting the interrupt mask, returning from an interrupt, or pulling the status register from the stack. The set-status-bits instruction is allowed, but its immediate operand on the cycle after the fetch is inspected, and the block flags it only when that mask would set the interrupt-disable bit.

A flagged fetch raises the abort request combinationally in the same bus cycle, so the processor drops the instruction long before any locked read-modify-write phase. A 3-bit cause code is held from the first violation until the supervisor pulses the clear input, so the abort handler can read why control was taken. Supervisor mode lets every instruction through. Switching between modes happens outside this block.

Top module: `op_filter`

## Requirements
- R1: After reset, `abort_o` is low and `viol_code_o` is 0.
- R2: On an opcode fetch (`vda_i`=1, `vpa_i`=1) in user mode with `abort_en_i`=1, `abort_o` is high in that same cycle when the byte is 0xDB, 0xFB, 0x78, 0x40 or 0x28. The cause codes for these bytes are 1, 2, 3, 4 and 5 in that order.
- R3: While `user_mode_i` is 0, no byte raises `abort_o` and `viol_code_o` does not change.
- R4: A forbidden byte on a cycle that is not an opcode fetch does not raise `abort_o`.
- R5: After a user-mode fetch of 0xE2, an operand cycle (`vda_i`=0, `vpa_i`=1) on the very next cycle raises `abort_o` with cause code 6 if data bit 2 is set. If that bit is clear, nothing happens. The 0xE2 fetch does not abort by itself.
- R6: The operand check applies only to the cycle right after the 0xE2 fetch. An operand cycle that follows anything else is not checked.
- R7: When `abort_en_i` is 0, `abort_o` stays low, but the violation is still recorded in `viol_code_o`.
- R8: `viol_code_o` takes the code of the first violation and keeps it through later violations.
- R9: A pulse on `clear_i` sets `viol_code_o` to 0 at the next edge. If a violation occurs in the same cycle as the clear, its code is stored instead of 0.
- R10: Allowed opcodes fetched in user mode (for example 0x18, 0xEA) raise no abort and store no code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vda_i | input | 1 | Valid data address strobe |
| vpa_i | input | 1 | Valid program address strobe |
| data_i | input | 8 | Data bus snoop |
| user_mode_i | input | 1 | High while in user mode |
| abort_en_i | input | 1 | Enables the abort output |
| clear_i | input | 1 | Clears the stored cause code |
| abort_o | output | 1 | Abort request, combinational |
| viol_code_o | output | 3 | Sticky cause code, 0 means none |

## Verification
Two functions can fall on the same edge: the supervisor's clear of the stored cause and the capture of a new violation. The bench drives `clear_i` high during the operand cycle of a 0xE2 fetch whose mask has bit 2 set, at a time when an older code is already stored. It expects code 6 to be held afterwards, not 0 and not the old code. A second pair of cases runs a clear on an idle cycle and a violation while a code is already stored. Together these separate the clear path from the capture path and from the first-violation-wins rule.

// File: rtl/op_filter_pkg.sv
package op_filter_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned CODE_W = 3;
  localparam int unsigned IMASK_BIT = 2;

  typedef enum logic [CODE_W-1:0] {
    CAUSE_NONE  = 3'd0,
    CAUSE_HALT  = 3'd1,
    CAUSE_EXCH  = 3'd2,
    CAUSE_MASK  = 3'd3,
    CAUSE_RETI  = 3'd4,
    CAUSE_PULLS = 3'd5,
    CAUSE_SETI  = 3'd6
  } cause_e;

  localparam logic [DATA_W-1:0] OPC_HALT  = 8'hDB;
  localparam logic [DATA_W-1:0] OPC_EXCH  = 8'hFB;
  localparam logic [DATA_W-1:0] OPC_MASK  = 8'h78;
  localparam logic [DATA_W-1:0] OPC_RETI  = 8'h40;
  localparam logic [DATA_W-1:0] OPC_PULLS = 8'h28;
  localparam logic [DATA_W-1:0] OPC_SETS  = 8'hE2;
endpackage

// File: rtl/op_decode.sv
module op_decode
  import op_filter_pkg::*;
(
  input  logic [DATA_W-1:0] opc_i,
  output cause_e            cause_o,
  output logic              is_sets_o
);
  always_comb begin
    unique case (opc_i)
      OPC_HALT:  cause_o = CAUSE_HALT;
      OPC_EXCH:  cause_o = CAUSE_EXCH;
      OPC_MASK:  cause_o = CAUSE_MASK;
      OPC_RETI:  cause_o = CAUSE_RETI;
      OPC_PULLS: cause_o = CAUSE_PULLS;
      default:   cause_o = CAUSE_NONE;
    endcase
  end
  assign is_sets_o = (opc_i == OPC_SETS);
endmodule

// File: rtl/operand_track.sv
module operand_track
  import op_filter_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arm_i,
  input  logic              opnd_cycle_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              hit_o
);
  logic armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= arm_i;
  end

  // only the cycle straight after the status-set fetch carries its mask
  assign hit_o = armed_q && opnd_cycle_i && data_i[IMASK_BIT];
endmodule

// File: rtl/cause_hold.sv
module cause_hold
  import op_filter_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hit_i,
  input  cause_e            cause_i,
  input  logic              clear_i,
  output logic [CODE_W-1:0] code_o
);
  logic [CODE_W-1:0] code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '0;
    end else if (hit_i && (clear_i || code_q == '0)) begin
      code_q <= cause_i;
    end else if (clear_i) begin
      code_q <= '0;
    end
  end

  assign code_o = code_q;
endmodule

// File: rtl/op_filter.sv
module op_filter
  import op_filter_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vda_i,
  input  logic              vpa_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              user_mode_i,
  input  logic              abort_en_i,
  input  logic              clear_i,
  output logic              abort_o,
  output logic [CODE_W-1:0] viol_code_o
);
  cause_e fetch_cause;
  cause_e cause;
  logic   fetch_sets;
  logic   opc_fetch;
  logic   opnd_cycle;
  logic   seti_hit;
  logic   fetch_hit;
  logic   hit;

  assign opc_fetch  = vda_i && vpa_i && user_mode_i;
  assign opnd_cycle = !vda_i && vpa_i && user_mode_i;

  op_decode u_decode (
    .opc_i     (data_i),
    .cause_o   (fetch_cause),
    .is_sets_o (fetch_sets)
  );

  operand_track u_track (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .arm_i        (opc_fetch && fetch_sets),
    .opnd_cycle_i (opnd_cycle),
    .data_i       (data_i),
    .hit_o        (seti_hit)
  );

  assign fetch_hit = opc_fetch && (fetch_cause != CAUSE_NONE);
  assign hit       = fetch_hit || seti_hit;
  assign cause     = seti_hit ? CAUSE_SETI : fetch_cause;
  assign abort_o   = abort_en_i && hit;

  cause_hold u_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hit_i   (hit),
    .cause_i (cause),
    .clear_i (clear_i),
    .code_o  (viol_code_o)
  );
endmodule

// File: rtl/op_filter_chk.sv
module op_filter_chk
  import op_filter_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              vda_i,
  input logic              vpa_i,
  input logic [DATA_W-1:0] data_i,
  input logic              user_mode_i,
  input logic              abort_en_i,
  input logic              clear_i,
  input logic              abort_o,
  input logic [CODE_W-1:0] viol_code_o
);
  a_r3_supervisor_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !user_mode_i |-> !abort_o);

  a_r4_program_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> vpa_i);

  a_r7_enable_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !abort_en_i |-> !abort_o);

  a_r5_operand_follows_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abort_o && !vda_i) |-> $past(vda_i && vpa_i && user_mode_i && data_i == OPC_SETS));

  a_r2_abort_records: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abort_o && viol_code_o == '0) |=> viol_code_o != '0);

  a_r8_first_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (viol_code_o != '0 && !clear_i) |=> $stable(viol_code_o));

  a_r9_clear_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_i && !(user_mode_i && vpa_i)) |=> viol_code_o == '0);
endmodule

bind op_filter op_filter_chk u_chk (.*);

// File: tb/tb_op_filter.sv
module tb_op_filter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       vda = 1'b0, vpa = 1'b0, um = 1'b0, aen = 1'b1, clr = 1'b0;
  logic [7:0] data = 8'h00;
  logic       abort;
  logic [2:0] code;
  int         n_chk = 0;
  int         n_bad = 0;

  always #2 clk = ~clk;

  op_filter dut (
    .clk_i(clk), .rst_ni(rst_n), .vda_i(vda), .vpa_i(vpa), .data_i(data),
    .user_mode_i(um), .abort_en_i(aen), .clear_i(clr),
    .abort_o(abort), .viol_code_o(code)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drive one bus cycle after the falling edge, settle, leave caller to sample
  task automatic step(input logic v_d, input logic v_p, input logic [7:0] d,
                      input logic u, input logic c);
    @(negedge clk);
    vda = v_d; vpa = v_p; data = d; um = u; clr = c;
    #1;
  endtask

  task automatic idle();
    step(1'b0, 1'b0, 8'h00, um, 1'b0);
  endtask

  task automatic wipe();
    step(1'b0, 1'b0, 8'h00, 1'b1, 1'b1);
    idle();
  endtask

  task automatic t_reset();
    chk("R1 abort", abort, 0);
    chk("R1 code", code, 0);
  endtask

  task automatic t_forbidden();
    logic [7:0] ops [5] = '{8'hDB, 8'hFB, 8'h78, 8'h40, 8'h28};
    for (int i = 0; i < 5; i++) begin
      wipe();
      chk("R9 cleared", code, 0);
      step(1'b1, 1'b1, ops[i], 1'b1, 1'b0);
      chk("R2 abort", abort, 1);
      idle();
      chk("R2 code", code, i + 1);
    end
  endtask

  task automatic t_supervisor();
    wipe();
    step(1'b1, 1'b1, 8'hDB, 1'b0, 1'b0);
    chk("R3 abort", abort, 0);
    step(1'b1, 1'b1, 8'h78, 1'b0, 1'b0);
    chk("R3 abort", abort, 0);
    idle();
    chk("R3 code", code, 0);
  endtask

  task automatic t_nonfetch();
    wipe();
    step(1'b1, 1'b0, 8'hDB, 1'b1, 1'b0);
    chk("R4 data cycle", abort, 0);
    step(1'b0, 1'b1, 8'hFB, 1'b1, 1'b0);
    chk("R4 operand cycle", abort, 0);
    idle();
    chk("R4 code", code, 0);
  endtask

  task automatic t_sets();
    wipe();
    step(1'b1, 1'b1, 8'hE2, 1'b1, 1'b0);
    chk("R5 sets fetch", abort, 0);
    step(1'b0, 1'b1, 8'hFB, 1'b1, 1'b0);
    chk("R5 mask bit clear", abort, 0);
    idle();
    chk("R5 code clear mask", code, 0);
    step(1'b1, 1'b1, 8'hE2, 1'b1, 1'b0);
    step(1'b0, 1'b1, 8'h04, 1'b1, 1'b0);
    chk("R5 mask bit set", abort, 1);
    idle();
    chk("R5 code", code, 6);
  endtask

  task automatic t_window();
    wipe();
    step(1'b1, 1'b1, 8'hE2, 1'b1, 1'b0);
    step(1'b1, 1'b1, 8'h04, 1'b1, 1'b0);
    chk("R6 fetch after sets", abort, 0);
    step(1'b0, 1'b1, 8'hFF, 1'b1, 1'b0);
    chk("R6 late operand", abort, 0);
    step(1'b0, 1'b1, 8'hFF, 1'b1, 1'b0);
    chk("R6 unarmed operand", abort, 0);
    idle();
    chk("R6 code", code, 0);
  endtask

  task automatic t_gate();
    wipe();
    aen = 1'b0;
    step(1'b1, 1'b1, 8'h40, 1'b1, 1'b0);
    chk("R7 abort gated", abort, 0);
    idle();
    chk("R7 code kept", code, 4);
    aen = 1'b1;
  endtask

  task automatic t_sticky();
    wipe();
    step(1'b1, 1'b1, 8'h28, 1'b1, 1'b0);
    step(1'b1, 1'b1, 8'hDB, 1'b1, 1'b0);
    chk("R8 second abort", abort, 1);
    idle();
    chk("R8 first kept", code, 5);
  endtask

  task automatic t_clear_race();
    wipe();
    step(1'b1, 1'b1, 8'hFB, 1'b1, 1'b0);
    idle();
    chk("R9 pre code", code, 2);
    step(1'b1, 1'b1, 8'hE2, 1'b1, 1'b0);
    step(1'b0, 1'b1, 8'h04, 1'b1, 1'b1);
    chk("R9 race abort", abort, 1);
    idle();
    chk("R9 race code", code, 6);
    step(1'b0, 1'b0, 8'h00, 1'b1, 1'b1);
    idle();
    chk("R9 idle clear", code, 0);
  endtask

  task automatic t_allowed();
    wipe();
    step(1'b1, 1'b1, 8'h18, 1'b1, 1'b0);
    chk("R10 clc", abort, 0);
    step(1'b1, 1'b1, 8'hEA, 1'b1, 1'b0);
    chk("R10 nop", abort, 0);
    idle();
    chk("R10 code", code, 0);
  endtask

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_forbidden();
    t_supervisor();
    t_nonfetch();
    t_sets();
    t_window();
    t_gate();
    t_sticky();
    t_clear_race();
    t_allowed();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule